// File: doc/BRIEF.md
# Flash Page Program Staging Buffer

This block sits between the command decoder of a serial NOR flash and its array. While a page-program command streams in, it stores each received data byte in a page-sized buffer and marks that byte position as present. The decoder hands the buffer the start address when the command opens, one strobe per received byte, and then either an abort (the command was malformed or rejected) or a commit (the command closed cleanly).

Received bytes land at the running offset within one page. When the offset passes the last byte, it wraps to offset zero of the same page. If more bytes arrive than the page holds, later bytes overwrite earlier ones, so the last page-worth received is what gets programmed. On commit the buffer visits every marked position in ascending offset order. For each one it reads the old array byte and, on the next cycle, writes back the old byte ANDed with the buffered byte, because programming can only clear bits. Unmarked positions are never touched.

The controller has five states. ST_IDLE waits for a start. ST_FILL collects bytes: a start restarts it, an abort returns it to ST_IDLE, and a commit moves it to ST_SCAN (or straight to ST_DONE for an illegal address). ST_SCAN issues a read for the lowest marked byte and moves to ST_READ, or moves to ST_DONE when nothing is marked. ST_READ issues the write and returns to ST_SCAN. ST_DONE raises done for one cycle and returns to ST_IDLE.

Top module: `pgbuf_page_prog`

## Requirements
- R1: After reset the block is in ST_IDLE with busy, done, mem_rd_en and mem_wr_en all low.
- R2: A cmd_start in ST_IDLE or ST_FILL clears every byte mark, takes the page number from cmd_addr[ARRAY_AW-1:OFF_W] and the starting offset from cmd_addr[OFF_W-1:0], and enters ST_FILL.
- R3: Each byte_vld in ST_FILL stores byte_data at the current offset, marks it, and advances the offset by one. After offset PAGE_BYTES-1 the next offset is 0 of the same page, and every write address carries the latched page number.
- R4: When more than PAGE_BYTES bytes are received, a position written again keeps its latest byte, so the final PAGE_BYTES bytes received are the ones programmed.
- R5: Array bytes of the page whose offsets received no byte are neither read nor written during commit.
- R6: The value written for a marked offset equals the array's old byte ANDed with the buffered byte. No bit goes from 0 to 1.
- R7: During commit, marked offsets are processed in strictly ascending order. Each asserts mem_rd_en with address {page, offset} for one cycle, and mem_wr_en to the same address on the next cycle. mem_rd_data is expected one cycle after mem_rd_en.
- R8: done is high for exactly one cycle after the last write. A commit with no marked bytes gives done with no array access.
- R9: cmd_abort in ST_FILL discards the buffer and returns to ST_IDLE. A later commit without a new start is ignored: no access and no done.
- R10: If any bit of cmd_addr above ARRAY_AW-1 is 1 at start, the commit yields done with no array access.
- R11: A cmd_start while in ST_FILL discards the bytes collected so far. Only bytes received after it are programmed.
- R12: byte_vld, cmd_abort, cmd_start and cmd_commit are ignored while busy (ST_SCAN or ST_READ). The commit in progress completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Opens a program command, samples cmd_addr |
| cmd_addr | input | ADDR_W | Start address of the command |
| byte_vld | input | 1 | One received data byte on byte_data |
| byte_data | input | 8 | Received data byte |
| cmd_abort | input | 1 | Discards the command being collected |
| cmd_commit | input | 1 | Closes the command and starts the array update |
| busy | output | 1 | Array update in progress |
| done | output | 1 | One-cycle pulse when the update finishes |
| mem_rd_en | output | 1 | Array read request |
| mem_rd_addr | output | ARRAY_AW | Array read address |
| mem_rd_data | input | 8 | Array read data, one cycle after the request |
| mem_wr_en | output | 1 | Array write strobe |
| mem_wr_addr | output | ARRAY_AW | Array write address |
| mem_wr_data | output | 8 | Array write data |

## Verification
The bench builds the block with PAGE_BYTES=16, ARRAY_AW=8 and ADDR_W=12, giving sixteen pages of sixteen bytes and a four-bit field that must be zero. At this size, a wrap across the page end, an overflow of more than a page of bytes, a completely full page and a rejected high address each take only a few dozen cycles. Against a 256-byte array model, the bench checks the exact set and order of write addresses and the AND result.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_FILL = 3'd1,
        ST_SCAN = 3'd2,
        ST_READ = 3'd3,
        ST_DONE = 3'd4
    } pgbuf_state_e;

endpackage

// File: rtl/pgbuf_store.sv
module pgbuf_store #(
    parameter int PAGE_BYTES = 256,
    localparam int OFF_W = $clog2(PAGE_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_all,
    input  logic                  put_en,
    input  logic [OFF_W-1:0]      put_idx,
    input  logic [7:0]            put_data,
    input  logic                  drop_en,
    input  logic [OFF_W-1:0]      drop_idx,
    input  logic [OFF_W-1:0]      get_idx,
    output logic [7:0]            get_data,
    output logic [PAGE_BYTES-1:0] mark_vec
);

    logic [PAGE_BYTES-1:0][7:0] data_q;
    logic [PAGE_BYTES-1:0]      mark_q;

    always_ff @(posedge clk) begin
        for (int i = 0; i < PAGE_BYTES; i++) begin
            if (put_en && put_idx == OFF_W'(i)) begin
                data_q[i] <= put_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mark_q <= '0;
        end else if (clr_all) begin
            mark_q <= '0;
        end else begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (put_en && put_idx == OFF_W'(i)) begin
                    mark_q[i] <= 1'b1;
                end else if (drop_en && drop_idx == OFF_W'(i)) begin
                    mark_q[i] <= 1'b0;
                end
            end
        end
    end

    assign get_data = data_q[get_idx];
    assign mark_vec = mark_q;

    // R3
    property put_sets_mark_p;
        @(posedge clk) disable iff (!rst_n)
        (put_en && !clr_all) |=> mark_q[$past(put_idx)];
    endproperty
    put_sets_mark_chk: assert property (put_sets_mark_p);

    // R2
    property clr_empties_p;
        @(posedge clk) disable iff (!rst_n)
        clr_all |=> (mark_q == '0);
    endproperty
    clr_empties_chk: assert property (clr_empties_p);

endmodule

// File: rtl/pgbuf_first.sv
module pgbuf_first #(
    parameter int PAGE_BYTES = 256,
    localparam int OFF_W = $clog2(PAGE_BYTES)
) (
    input  logic [PAGE_BYTES-1:0] vec,
    output logic                  any,
    output logic [OFF_W-1:0]      idx
);

    logic [PAGE_BYTES:0]   seen;
    logic [PAGE_BYTES-1:0] pick;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_chain
        assign pick[g]   = vec[g] & ~seen[g];
        assign seen[g+1] = seen[g] | vec[g];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < PAGE_BYTES; i++) begin
            if (pick[i]) begin
                idx = idx | OFF_W'(i);
            end
        end
    end

    assign any = seen[PAGE_BYTES];

    // R7
    always_comb begin
        lowest_onehot_chk: assert ($onehot0(pick));
    end

endmodule

// File: rtl/pgbuf_ctrl.sv
module pgbuf_ctrl
    import pgbuf_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_start,
    input  logic         cmd_abort,
    input  logic         cmd_commit,
    input  logic         byte_vld,
    input  logic         start_bad,
    input  logic         any_mark,
    output pgbuf_state_e state,
    output logic         ld_cmd,
    output logic         clr_all,
    output logic         fill_we,
    output logic         rd_issue,
    output logic         wr_issue,
    output logic         busy,
    output logic         done
);

    pgbuf_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_start) state_d = ST_FILL;
            end
            ST_FILL: begin
                if (cmd_start)       state_d = ST_FILL;
                else if (cmd_abort)  state_d = ST_IDLE;
                else if (cmd_commit) state_d = start_bad ? ST_DONE : ST_SCAN;
            end
            ST_SCAN: begin
                state_d = any_mark ? ST_READ : ST_DONE;
            end
            ST_READ: begin
                state_d = ST_SCAN;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ld_cmd   = 1'b0;
        clr_all  = 1'b0;
        fill_we  = 1'b0;
        rd_issue = 1'b0;
        wr_issue = 1'b0;
        busy     = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ld_cmd  = cmd_start;
                clr_all = cmd_start;
            end
            ST_FILL: begin
                ld_cmd  = cmd_start;
                clr_all = cmd_start | cmd_abort;
                fill_we = byte_vld & ~cmd_start & ~cmd_abort;
            end
            ST_SCAN: begin
                busy     = 1'b1;
                rd_issue = any_mark;
            end
            ST_READ: begin
                busy     = 1'b1;
                wr_issue = 1'b1;
            end
            ST_DONE: begin
                done = 1'b1;
            end
            default: ;
        endcase
    end

    assign state = state_q;

    // R8
    property done_single_p;
        @(posedge clk) disable iff (!rst_n)
        done |=> !done;
    endproperty
    done_single_chk: assert property (done_single_p);

    // R7
    property read_then_write_p;
        @(posedge clk) disable iff (!rst_n)
        rd_issue |=> wr_issue;
    endproperty
    read_then_write_chk: assert property (read_then_write_p);

    // R9
    property abort_to_idle_p;
        @(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && cmd_abort && !cmd_start) |=> (state_q == ST_IDLE);
    endproperty
    abort_to_idle_chk: assert property (abort_to_idle_p);

    // R12
    property busy_holds_p;
        @(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ) |=> (state_q == ST_SCAN);
    endproperty
    busy_holds_chk: assert property (busy_holds_p);

endmodule

// File: rtl/pgbuf_page_prog.sv
module pgbuf_page_prog
    import pgbuf_pkg::*;
#(
    parameter int PAGE_BYTES = 256,
    parameter int ARRAY_AW   = 16,
    parameter int ADDR_W     = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_start,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic                byte_vld,
    input  logic [7:0]          byte_data,
    input  logic                cmd_abort,
    input  logic                cmd_commit,
    output logic                busy,
    output logic                done,
    output logic                mem_rd_en,
    output logic [ARRAY_AW-1:0] mem_rd_addr,
    input  logic [7:0]          mem_rd_data,
    output logic                mem_wr_en,
    output logic [ARRAY_AW-1:0] mem_wr_addr,
    output logic [7:0]          mem_wr_data
);

    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int PG_W  = ARRAY_AW - OFF_W;

    pgbuf_state_e          state;
    logic                  ld_cmd, clr_all, fill_we, rd_issue, wr_issue;
    logic [PG_W-1:0]       page_q;
    logic [OFF_W-1:0]      off_q;
    logic [OFF_W-1:0]      idx_q;
    logic                  bad_q;
    logic [PAGE_BYTES-1:0] mark_vec;
    logic                  any_mark;
    logic [OFF_W-1:0]      first_idx;
    logic [7:0]            buf_byte;

    pgbuf_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_start  (cmd_start),
        .cmd_abort  (cmd_abort),
        .cmd_commit (cmd_commit),
        .byte_vld   (byte_vld),
        .start_bad  (bad_q),
        .any_mark   (any_mark),
        .state      (state),
        .ld_cmd     (ld_cmd),
        .clr_all    (clr_all),
        .fill_we    (fill_we),
        .rd_issue   (rd_issue),
        .wr_issue   (wr_issue),
        .busy       (busy),
        .done       (done)
    );

    pgbuf_store #(.PAGE_BYTES(PAGE_BYTES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (clr_all),
        .put_en   (fill_we),
        .put_idx  (off_q),
        .put_data (byte_data),
        .drop_en  (wr_issue),
        .drop_idx (idx_q),
        .get_idx  (idx_q),
        .get_data (buf_byte),
        .mark_vec (mark_vec)
    );

    pgbuf_first #(.PAGE_BYTES(PAGE_BYTES)) u_first (
        .vec (mark_vec),
        .any (any_mark),
        .idx (first_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            off_q  <= '0;
            bad_q  <= 1'b0;
            idx_q  <= '0;
        end else begin
            if (ld_cmd) begin
                page_q <= cmd_addr[ARRAY_AW-1:OFF_W];
                off_q  <= cmd_addr[OFF_W-1:0];
                bad_q  <= |cmd_addr[ADDR_W-1:ARRAY_AW];
            end else if (fill_we) begin
                off_q <= off_q + 1'b1;
            end
            if (rd_issue) begin
                idx_q <= first_idx;
            end
        end
    end

    assign mem_rd_en   = rd_issue;
    assign mem_rd_addr = {page_q, first_idx};
    assign mem_wr_en   = wr_issue;
    assign mem_wr_addr = {page_q, idx_q};
    assign mem_wr_data = mem_rd_data & buf_byte;

    logic             prev_vld_q;
    logic [OFF_W-1:0] prev_off_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_vld_q <= 1'b0;
            prev_off_q <= '0;
        end else if (state == ST_FILL) begin
            prev_vld_q <= 1'b0;
        end else if (mem_wr_en) begin
            prev_vld_q <= 1'b1;
            prev_off_q <= mem_wr_addr[OFF_W-1:0];
        end
    end

    // R7
    property wr_follows_rd_p;
        @(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> (mem_wr_en && mem_wr_addr == $past(mem_rd_addr));
    endproperty
    wr_follows_rd_chk: assert property (wr_follows_rd_p);

    // R7
    property ascending_p;
        @(posedge clk) disable iff (!rst_n)
        (mem_wr_en && prev_vld_q) |-> (mem_wr_addr[OFF_W-1:0] > prev_off_q);
    endproperty
    ascending_chk: assert property (ascending_p);

    // R6
    property clear_only_p;
        @(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ((mem_wr_data & ~mem_rd_data) == 8'h00);
    endproperty
    clear_only_chk: assert property (clear_only_p);

    // R10
    property bad_no_access_p;
        @(posedge clk) disable iff (!rst_n)
        (state == ST_FILL && cmd_commit && !cmd_start && !cmd_abort && bad_q) |=> done;
    endproperty
    bad_no_access_chk: assert property (bad_no_access_p);

    // R12
    property busy_page_stable_p;
        @(posedge clk) disable iff (!rst_n)
        busy |=> $stable(page_q);
    endproperty
    busy_page_stable_chk: assert property (busy_page_stable_p);

endmodule

// File: tb/pgbuf_page_prog_bench.sv
`timescale 1ns/100ps
module pgbuf_page_prog_bench;

    localparam int PB  = 16;
    localparam int AAW = 8;
    localparam int AW  = 12;
    localparam int NA  = 1 << AAW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cmd_start = 1'b0;
    logic [AW-1:0]  cmd_addr = '0;
    logic           byte_vld = 1'b0;
    logic [7:0]     byte_data = '0;
    logic           cmd_abort = 1'b0;
    logic           cmd_commit = 1'b0;
    logic           busy, done, mem_rd_en, mem_wr_en;
    logic [AAW-1:0] mem_rd_addr, mem_wr_addr;
    logic [7:0]     mem_wr_data;
    logic [7:0]     mem_rd_data = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pgbuf_page_prog #(.PAGE_BYTES(PB), .ARRAY_AW(AAW), .ADDR_W(AW)) u_pgbuf_page_prog (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
        .byte_vld(byte_vld), .byte_data(byte_data), .cmd_abort(cmd_abort),
        .cmd_commit(cmd_commit), .busy(busy), .done(done),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    logic [7:0]     arr [NA];
    logic [7:0]     old_arr [NA];
    logic [AAW-1:0] wlog [64];
    int             n_wr = 0;
    int             n_rd = 0;

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= arr[mem_rd_addr];
            n_rd <= n_rd + 1;
        end
        if (mem_wr_en) begin
            arr[mem_wr_addr] <= mem_wr_data;
            if (n_wr < 64) wlog[n_wr] <= mem_wr_addr;
            n_wr <= n_wr + 1;
        end
    end

    // bench model of the buffer
    logic [7:0]      eb [PB];
    bit              ev [PB];
    int              e_off;
    int              e_page;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic start_cmd(input logic [AW-1:0] a);
        @(negedge clk);
        cmd_start = 1'b1; cmd_addr = a;
        @(negedge clk);
        cmd_start = 1'b0;
        for (int i = 0; i < PB; i++) ev[i] = 0;
        e_off  = int'(a) % PB;
        e_page = (int'(a) / PB) % (NA / PB);
    endtask

    task automatic send_byte(input logic [7:0] d);
        byte_vld = 1'b1; byte_data = d;
        @(negedge clk);
        byte_vld = 1'b0;
        eb[e_off] = d; ev[e_off] = 1;
        e_off = (e_off + 1) % PB;
    endtask

    // pulse commit, wait for done, return done count
    task automatic commit_wait(output int dones, output int wr0);
        for (int i = 0; i < NA; i++) old_arr[i] = arr[i];
        wr0 = n_wr;
        dones = 0;
        cmd_commit = 1'b1;
        @(negedge clk);
        cmd_commit = 1'b0;
        for (int c = 0; c < 3 * PB + 20; c++) begin
            if (done) dones++;
            @(negedge clk);
        end
    endtask

    // compare array and write order against the model
    task automatic verify(input string req, input int wr0);
        int k;
        k = wr0;
        for (int o = 0; o < PB; o++) begin
            int a;
            logic [7:0] exp;
            a = e_page * PB + o;
            exp = ev[o] ? (old_arr[a] & eb[o]) : old_arr[a];
            check(arr[a] == exp, req, arr[a], exp);
            if (ev[o]) begin
                check(k < n_wr && wlog[k] == AAW'(a), {req, " R7 order"},
                      (k < n_wr) ? int'(wlog[k]) : -1, a);
                k++;
            end
        end
        check(n_wr == k, {req, " R5 write count"}, n_wr - wr0, k - wr0);
    endtask

    task automatic t_reset;
        check(!busy && !done && !mem_rd_en && !mem_wr_en, "R1 reset outputs",
              {busy, done, mem_rd_en, mem_wr_en}, 0);
    endtask

    task automatic t_partial;
        int d, w;
        start_cmd(12'h033);
        send_byte(8'h0F); send_byte(8'hF0); send_byte(8'h5A); send_byte(8'h00);
        commit_wait(d, w);
        check(d == 1, "R8 one done pulse", d, 1);
        verify("R6 R2 partial page", w);
    endtask

    task automatic t_wrap;
        int d, w;
        start_cmd(12'h04E);
        send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
        send_byte(8'h44); send_byte(8'h55);
        commit_wait(d, w);
        check(d == 1, "R3 done after wrap", d, 1);
        verify("R3 wrap in page", w);
    endtask

    task automatic t_overflow;
        int d, w;
        start_cmd(12'h065);
        for (int i = 0; i < PB + 4; i++) send_byte(8'(8'hFF - i * 7));
        commit_wait(d, w);
        check(d == 1, "R4 done after overflow", d, 1);
        verify("R4 last page-worth kept", w);
    endtask

    task automatic t_full;
        int d, w;
        start_cmd(12'h070);
        for (int i = 0; i < PB; i++) send_byte(8'(i * 13));
        commit_wait(d, w);
        verify("R6 full page", w);
    endtask

    task automatic t_empty;
        int d, w;
        start_cmd(12'h080);
        commit_wait(d, w);
        check(d == 1, "R8 empty commit done", d, 1);
        check(n_wr == w, "R8 empty commit no write", n_wr - w, 0);
    endtask

    task automatic t_abort;
        int d, w, r0;
        start_cmd(12'h090);
        send_byte(8'h00); send_byte(8'h00);
        cmd_abort = 1'b1;
        @(negedge clk);
        cmd_abort = 1'b0;
        r0 = n_rd;
        commit_wait(d, w);
        check(d == 0, "R9 abort no done", d, 0);
        check(n_wr == w && n_rd == r0, "R9 abort no access", n_wr - w, 0);
    endtask

    task automatic t_bad_addr;
        int d, w, r0;
        start_cmd(12'h1A0);
        send_byte(8'h00); send_byte(8'h00);
        r0 = n_rd;
        commit_wait(d, w);
        check(d == 1, "R10 high address done", d, 1);
        check(n_wr == w && n_rd == r0, "R10 high address no access", n_wr - w, 0);
    endtask

    task automatic t_restart;
        int d, w;
        start_cmd(12'h0B0);
        send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
        start_cmd(12'h0C4);
        send_byte(8'h3C); send_byte(8'hC3);
        commit_wait(d, w);
        verify("R11 restart discards", w);
        check(arr[8'hB0] == old_arr[8'hB0], "R11 old page untouched", arr[8'hB0], old_arr[8'hB0]);
    endtask

    task automatic t_busy_ignore;
        int d, w;
        start_cmd(12'h0D2);
        send_byte(8'h81); send_byte(8'h18);
        for (int i = 0; i < NA; i++) old_arr[i] = arr[i];
        w = n_wr; d = 0;
        cmd_commit = 1'b1;
        @(negedge clk);
        cmd_commit = 1'b0;
        check(busy == 1'b1, "R12 busy after commit", busy, 1);
        byte_vld = 1'b1; byte_data = 8'h00; cmd_abort = 1'b1; cmd_start = 1'b1;
        cmd_addr = 12'h0E0;
        @(negedge clk);
        byte_vld = 1'b0; cmd_abort = 1'b0; cmd_start = 1'b0;
        for (int c = 0; c < 20; c++) begin
            if (done) d++;
            @(negedge clk);
        end
        check(d == 1, "R12 done despite strobes", d, 1);
        verify("R12 busy strobes ignored", w);
        commit_wait(d, w);
        check(d == 0 && n_wr == w, "R12 stray commit in idle ignored", d, 0);
    endtask

    initial begin
        for (int i = 0; i < NA; i++) arr[i] = 8'(i * 29 + 8'hC7) | 8'h81;
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_partial;
        t_wrap;
        t_overflow;
        t_full;
        t_empty;
        t_abort;
        t_bad_addr;
        t_restart;
        t_busy_ignore;
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule